// File: doc/BRIEF.md
# Four-Mode Counter/Timer

This block is a sixteen-bit counter/timer whose count is held in two bytes, low and high, that software reads and writes on their own through a small byte-wide register port. A mode field selects one of four ways of using those bytes: a 13-bit counter, a full 16-bit counter, an 8-bit counter that reloads from the high byte, or two unrelated 8-bit counters. On wrap-around the block raises a sticky overflow flag. The flag, ANDed with its enable bit, drives an interrupt request.

The counting source is chosen per configuration. It is either every system clock, or only the cycles in which an externally generated prescale tick is high, or falling edges of an asynchronous event pin. The event pin passes through a two-flop synchronizer, and an edge is recognised when the synchronized level drops. Each level of the event signal must therefore last at least two system clocks, which limits counted events to a quarter of the clock rate.

Top module: `cntr_timer4`

## Requirements
- R1: After reset every register reads zero, and `ovf_flag`, `ovf_flag_hi` and `irq` are low.
- R2: A write (`reg_wr` high) takes effect at the next rising clock edge and has priority over counting. `reg_rdata` shows the addressed register combinationally. Address 0 is control: bit0 run, bit1 run_hi, bit2 ien, bit3 ien_hi, bit4 flag, bit5 flag_hi. Address 1 is configuration: bits1:0 mode (0=13-bit, 1=16-bit, 2=8-bit reload, 3=split), bit2 event source, bit3 prescaled clock. Address 2 is the low byte and address 3 the high byte.
- R3: The count does not change while run is clear.
- R4: In mode 1, {high,low} increments once per count tick. The step from 0xFFFF to 0x0000 sets the flag.
- R5: In mode 0 the 13-bit value is {high, low[4:0]}. The step from 0x1FFF to 0x0000 sets the flag.
- R6: In mode 0, low[7:5] keep their written value and do not affect the count.
- R7: In mode 2, only the low byte counts. When it is 0xFF, the next tick loads it from the high byte and sets the flag. The high byte is left unchanged.
- R8: In mode 3, the high byte is a separate 8-bit counter gated by run_hi and driven by the clock source (never by events). Its wrap from 0xFF sets flag_hi and leaves flag clear.
- R9: A flag stays set until a control write puts 0 in its bit. A hardware set in the same cycle wins.
- R10: `irq` is high exactly when (flag and ien) or (flag_hi and ien_hi).
- R11: With the event source selected, each falling edge on `evt_in` counts once, and rising edges count nothing. Each level lasts at least two clocks, and the count settles within three clocks of the edge.
- R12: With the prescaled clock selected (and the event source not selected), the count advances only in cycles where `pre_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| evt_in | input | 1 | Asynchronous event pin |
| pre_tick | input | 1 | Prescale enable pulse |
| ovf_flag | output | 1 | Main overflow flag |
| ovf_flag_hi | output | 1 | High-byte overflow flag (split mode) |
| irq | output | 1 | Interrupt request |

## Verification
The bench starts each mode one or two ticks before its wrap point. In 13-bit mode a counter that carried out of bit 7 instead of bit 4, or that cleared the three upper low-byte bits, would show a wrong high byte or a wrong low byte (0x00 instead of 0xE0). In reload mode a design that reloaded with zero, or that also counted the high byte, is caught by reading both bytes after the wrap. Event counting is driven with pulses at the minimum two-clock width: a detector that also counted rising edges would report 6 instead of 3. The bench also checks that a flag survives further counting and that the interrupt follows the enable bit.

// File: rtl/cntr_timer4.sv
module cntr_timer4 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       evt_in,
  input  logic       pre_tick,
  output logic       ovf_flag,
  output logic       ovf_flag_hi,
  output logic       irq
);
  logic       run, run_hi, ien, ien_hi, flag, flag_hi;
  logic [1:0] mode;
  logic       src_evt, src_pre;
  logic [7:0] lo, hi, lo_n, hi_n;
  logic [2:0] sync;
  logic       evt_fall, clk_tick, tick_lo, tick_hi, set_lo, set_hi;
  logic [12:0] v13_inc;
  logic [15:0] v16_inc;

  assign evt_fall = sync[2] & ~sync[1];
  assign clk_tick = src_pre ? pre_tick : 1'b1;
  assign tick_lo  = run & (src_evt ? evt_fall : clk_tick);
  assign tick_hi  = run_hi & clk_tick;
  assign v13_inc  = {hi, lo[4:0]} + 13'd1;
  assign v16_inc  = {hi, lo} + 16'd1;

  always_comb begin
    lo_n = lo;
    hi_n = hi;
    set_lo = 1'b0;
    set_hi = 1'b0;
    case (mode)
      2'd0: if (tick_lo) begin
        lo_n[4:0] = v13_inc[4:0];
        hi_n      = v13_inc[12:5];
        set_lo    = ({hi, lo[4:0]} == 13'h1FFF);
      end
      2'd1: if (tick_lo) begin
        {hi_n, lo_n} = v16_inc;
        set_lo       = ({hi, lo} == 16'hFFFF);
      end
      2'd2: if (tick_lo) begin
        set_lo = (lo == 8'hFF);
        lo_n   = set_lo ? hi : lo + 8'd1;
      end
      default: begin
        if (tick_lo) begin
          lo_n   = lo + 8'd1;
          set_lo = (lo == 8'hFF);
        end
        if (tick_hi) begin
          hi_n   = hi + 8'd1;
          set_hi = (hi == 8'hFF);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {run, run_hi, ien, ien_hi, flag, flag_hi} <= '0;
      {mode, src_evt, src_pre} <= '0;
      lo <= '0;
      hi <= '0;
      sync <= '0;
    end else begin
      sync <= {sync[1:0], evt_in};
      if (reg_wr && reg_addr == 2'd0) begin
        {run, run_hi, ien, ien_hi} <= {reg_wdata[0], reg_wdata[1], reg_wdata[2], reg_wdata[3]};
        flag    <= set_lo | reg_wdata[4];
        flag_hi <= set_hi | reg_wdata[5];
      end else begin
        flag    <= set_lo | flag;
        flag_hi <= set_hi | flag_hi;
      end
      if (reg_wr && reg_addr == 2'd1)
        {src_pre, src_evt, mode} <= reg_wdata[3:0];
      lo <= (reg_wr && reg_addr == 2'd2) ? reg_wdata : lo_n;
      hi <= (reg_wr && reg_addr == 2'd3) ? reg_wdata : hi_n;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {2'b00, flag_hi, flag, ien_hi, ien, run_hi, run};
      2'd1:    reg_rdata = {4'h0, src_pre, src_evt, mode};
      2'd2:    reg_rdata = lo;
      default: reg_rdata = hi;
    endcase
  end

  assign ovf_flag    = flag;
  assign ovf_flag_hi = flag_hi;
  assign irq         = (flag & ien) | (flag_hi & ien_hi);
endmodule

module cntr_timer4_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic [1:0] mode,
  input logic       run,
  input logic       run_hi,
  input logic       tick_lo,
  input logic [7:0] lo,
  input logic [7:0] hi,
  input logic       ovf_flag,
  input logic       ovf_flag_hi,
  input logic       irq
);
  a_r3_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !run_hi && !reg_wr) |=> ($stable(lo) && $stable(hi)));
  a_r5_wrap13: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && tick_lo && hi == 8'hFF && lo[4:0] == 5'h1F && !reg_wr)
    |=> (ovf_flag && hi == 8'h00 && lo[4:0] == 5'h00));
  a_r6_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !reg_wr) |=> (lo[7:5] == $past(lo[7:5])));
  a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && tick_lo && lo == 8'hFF && !reg_wr) |=> (lo == $past(hi) && ovf_flag));
  a_r8_hi_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !run_hi && !reg_wr) |=> $stable(hi));
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !(reg_wr && reg_addr == 2'd0)) |=> ovf_flag);
  a_r10_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf_flag || ovf_flag_hi));
endmodule

bind cntr_timer4 cntr_timer4_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .mode(mode),
  .run(run), .run_hi(run_hi), .tick_lo(tick_lo), .lo(lo), .hi(hi),
  .ovf_flag(ovf_flag), .ovf_flag_hi(ovf_flag_hi), .irq(irq)
);

// File: tb/cntr_timer4_tb_top.sv
module cntr_timer4_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       evt_in = 1'b1;
  logic       pre_tick = 1'b0;
  logic       ovf_flag, ovf_flag_hi, irq;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cntr_timer4 dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
    .pre_tick(pre_tick), .ovf_flag(ovf_flag), .ovf_flag_hi(ovf_flag_hi), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic do_reset;
    rst_n = 1'b0; evt_in = 1'b1; pre_tick = 1'b0; reg_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset();
    for (int a = 0; a < 4; a++) rd_chk("R1 reg", a[1:0], 8'h00);
    chk("R1 flags/irq", {5'b0, ovf_flag, ovf_flag_hi, irq}, 8'h00);
  endtask

  task automatic t_mode16;
    do_reset();
    wr(1, 8'h01); wr(2, 8'hFE); wr(3, 8'hFF); wr(0, 8'h01);
    @(negedge clk);
    rd_chk("R4 lo", 2, 8'hFF); rd_chk("R4 hi", 3, 8'hFF); rd_chk("R4 ctrl", 0, 8'h01);
    @(negedge clk);
    rd_chk("R4 lo wrap", 2, 8'h00); rd_chk("R4 hi wrap", 3, 8'h00);
    rd_chk("R4 flag", 0, 8'h11);
    chk("R10 irq masked", {7'b0, irq}, 8'h00);
    repeat (5) @(negedge clk);
    rd_chk("R9 sticky", 0, 8'h11);
    rd_chk("R2 count continues", 2, 8'h05);
    wr(0, 8'h01);
    rd_chk("R9 cleared", 0, 8'h01);
  endtask

  task automatic t_mode13;
    do_reset();
    wr(1, 8'h00); wr(2, 8'hBF); wr(3, 8'h05); wr(0, 8'h01);
    @(negedge clk);
    rd_chk("R5 carry lo", 2, 8'hA0); rd_chk("R5 carry hi", 3, 8'h06);
    do_reset();
    wr(2, 8'hFE); wr(3, 8'hFF); wr(0, 8'h01);
    repeat (2) @(negedge clk);
    rd_chk("R6 upper kept", 2, 8'hE0); rd_chk("R5 hi wrap", 3, 8'h00);
    rd_chk("R5 flag", 0, 8'h11);
  endtask

  task automatic t_reload;
    do_reset();
    wr(1, 8'h02); wr(2, 8'hFE); wr(3, 8'hF0); wr(0, 8'h01);
    @(negedge clk);
    rd_chk("R7 lo", 2, 8'hFF); rd_chk("R7 no flag", 0, 8'h01);
    @(negedge clk);
    rd_chk("R7 reloaded", 2, 8'hF0); rd_chk("R7 flag", 0, 8'h11);
    @(negedge clk);
    rd_chk("R7 after", 2, 8'hF1); rd_chk("R7 hi kept", 3, 8'hF0);
  endtask

  task automatic t_split;
    do_reset();
    wr(1, 8'h03); wr(2, 8'h33); wr(3, 8'hFE); wr(0, 8'h02);
    repeat (2) @(negedge clk);
    rd_chk("R8 hi wrap", 3, 8'h00); rd_chk("R8 lo idle", 2, 8'h33);
    rd_chk("R8 flag_hi only", 0, 8'h22);
    chk("R8 port flags", {6'b0, ovf_flag, ovf_flag_hi}, 8'h01);
  endtask

  task automatic t_irq;
    do_reset();
    wr(1, 8'h01); wr(2, 8'hFF); wr(3, 8'hFF); wr(0, 8'h05);
    @(negedge clk);
    chk("R10 irq on", {7'b0, irq}, 8'h01);
    wr(0, 8'h04);
    chk("R10 irq cleared", {6'b0, ovf_flag, irq}, 8'h00);
  endtask

  task automatic t_event;
    do_reset();
    wr(1, 8'h05); wr(0, 8'h01);
    repeat (3) begin
      evt_in = 1'b0; repeat (2) @(negedge clk);
      evt_in = 1'b1; repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    rd_chk("R11 three falls", 2, 8'h03);
    evt_in = 1'b0; repeat (10) @(negedge clk);
    rd_chk("R11 long low once", 2, 8'h04);
  endtask

  task automatic t_prescale;
    do_reset();
    wr(1, 8'h09); wr(0, 8'h01);
    repeat (5) @(negedge clk);
    rd_chk("R12 no tick", 2, 8'h00);
    pre_tick = 1'b1; repeat (4) @(negedge clk); pre_tick = 1'b0;
    repeat (3) @(negedge clk);
    rd_chk("R12 four ticks", 2, 8'h04);
  endtask

  task automatic t_stopped;
    do_reset();
    wr(1, 8'h01); wr(2, 8'h05);
    repeat (10) @(negedge clk);
    rd_chk("R3 held", 2, 8'h05); rd_chk("R2 mode read", 1, 8'h01);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_mode16();
    t_mode13();
    t_reload();
    t_split();
    t_irq();
    t_event();
    t_prescale();
    t_stopped();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule